// File: doc/BRIEF.md
# Slave-mode timer counter

This block is an up/down counter whose clocking is governed by a three-bit slave-mode field. Depending on the mode, the counter advances on the internal clock, on edges of two filtered channel inputs decoded as a quadrature pair, or on a selected trigger. The trigger can also restart the counter, gate it, or start it. The count wraps between zero and a programmable auto-reload value, and every wrap or restart produces a one-cycle update pulse.

All channel and trigger inputs pass through one register stage before an edge is detected. An edge is then found by comparing the registered sample with the sample before it. The trigger source is picked by a two-bit select. That select is only taken in while slave control is off, so a change made while a slave mode runs has no effect.

Top module: `slave_timer`

## Requirements
- R1: During and right after reset the count is 0, the direction output is 0 (0 = up, 1 = down), and the update output is 0.
- R2: With mode 000 the count moves by one on every clock while `cnt_en` is 1, up when `dir_cfg` is 0 and down when it is 1. It holds while `cnt_en` is 0.
- R3: Counting up from a value equal to or above `arr` gives 0. Counting down from 0 gives `arr`. Either wrap makes `upd_o` high for exactly that one cycle.
- R4: With mode 001 (and `cnt_en` high) the counter steps once per edge of channel 0. It counts up when the new channel-0 level differs from the channel-1 level and down otherwise. `dir_o` shows the direction of the last counted step.
- R5: With mode 010 the counter steps once per edge of channel 1. It counts up when the new channel-1 level equals the channel-0 level and down otherwise.
- R6: With mode 011 edges of both channels count, each with the rule of R4 or R5. Channel 0 leading channel 1 gives up, so a full forward cycle 00,10,11,01,00 (ch0 ch1) adds 4.
- R7: With mode 100 a rising trigger reloads the count to 0 (dir_cfg 0) or to `arr` (dir_cfg 1) and pulses `upd_o`. This happens whether or not `cnt_en` is set.
- R8: With mode 101 and `cnt_en` high, the counter steps on each clock while the sampled trigger is high and holds while it is low.
- R9: With mode 110 a rising trigger starts the counter even with `cnt_en` low. It keeps counting after the trigger falls, for as long as the mode stays 110.
- R10: With mode 111 and `cnt_en` high, the counter steps once per rising trigger edge, however long the trigger stays high.
- R11: `trig_sel` picks the trigger: 00 = `trig_in`, 01 = channel 0, 10 = channel 1, 11 = none. It is captured only while the mode is 000, and is held in every other mode.
- R12: A channel or trigger change made before clock edge k takes effect on the count at edge k+1. At most one step is made per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal timer clock |
| rst_n | input | 1 | Active-low reset |
| cnt_en | input | 1 | Counter enable |
| mode | input | 3 | Slave-mode select |
| trig_sel | input | 2 | Trigger source select |
| dir_cfg | input | 1 | Direction for non-quadrature modes, 1 = down |
| arr | input | CNT_W | Auto-reload value |
| ch0_in | input | 1 | Filtered channel 0 |
| ch1_in | input | 1 | Filtered channel 1 |
| trig_in | input | 1 | External trigger |
| cnt_o | output | CNT_W | Counter value |
| dir_o | output | 1 | Current direction, 1 = down |
| upd_o | output | 1 | Update-event pulse |

## Verification
Changes of `cnt_en`, `mode` and `dir_cfg` act on the very next rising edge. A channel or trigger change is registered at the first edge and shows on the count at the second. The bench drives every input on a falling edge and waits the due number of rising edges, one or two. It then reads the outputs on the following falling edge. For gated and started counting, the expected totals are worked out from that two-edge delay, so the first and last counted edges are known exactly.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
    typedef enum logic [2:0] {
        SM_FREE    = 3'd0,
        SM_QA      = 3'd1,
        SM_QB      = 3'd2,
        SM_QAB     = 3'd3,
        SM_RESTART = 3'd4,
        SM_GATE    = 3'd5,
        SM_START   = 3'd6,
        SM_EXTCLK  = 3'd7
    } smode_e;

    typedef enum logic [1:0] {
        TS_EXT  = 2'd0,
        TS_CH0  = 2'd1,
        TS_CH1  = 2'd2,
        TS_NONE = 2'd3
    } tsrc_e;
endpackage

// File: rtl/tsc_insync.sv
module tsc_insync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] tog
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic cur_q, prev_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cur_q  <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                cur_q  <= din[i];
                prev_q <= cur_q;
            end
        end
        assign lvl[i] = cur_q;
        assign tog[i] = cur_q ^ prev_q;
    end
endmodule

// File: rtl/tsc_quad.sv
module tsc_quad
    import tsc_pkg::*;
(
    input  smode_e mode,
    input  logic   a_lvl,
    input  logic   b_lvl,
    input  logic   a_tog,
    input  logic   b_tog,
    output logic   step,
    output logic   down
);
    logic a_down, b_down;

    // ch0 leading ch1 counts up
    assign a_down = ~(a_lvl ^ b_lvl);
    assign b_down = a_lvl ^ b_lvl;

    always_comb begin
        step = 1'b0;
        down = 1'b0;
        unique case (mode)
            SM_QA: begin
                step = a_tog;
                down = a_down;
            end
            SM_QB: begin
                step = b_tog;
                down = b_down;
            end
            SM_QAB: begin
                step = a_tog ^ b_tog;
                down = a_tog ? a_down : b_down;
            end
            default: begin
                step = 1'b0;
                down = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/slave_timer.sv
module slave_timer
    import tsc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [2:0]       mode,
    input  logic [1:0]       trig_sel,
    input  logic             dir_cfg,
    input  logic [CNT_W-1:0] arr,
    input  logic             ch0_in,
    input  logic             ch1_in,
    input  logic             trig_in,
    output logic [CNT_W-1:0] cnt_o,
    output logic             dir_o,
    output logic             upd_o
);
    localparam int NSRC   = 3;
    localparam int IX_CH0 = 0;
    localparam int IX_CH1 = 1;
    localparam int IX_TRG = 2;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             dir;
        logic             upd;
        logic             run;
        tsrc_e            sel;
    } state_t;

    state_t st_d, st_q;
    smode_e mode_e;
    logic [NSRC-1:0] s_lvl, s_tog;
    logic trg_lvl, trg_tog, trg_rise;
    logic q_step, q_down;
    logic en, step, down, is_quad;

    assign mode_e = smode_e'(mode);

    tsc_insync #(.W(NSRC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({trig_in, ch1_in, ch0_in}),
        .lvl  (s_lvl),
        .tog  (s_tog)
    );

    tsc_quad u_quad (
        .mode (mode_e),
        .a_lvl(s_lvl[IX_CH0]),
        .b_lvl(s_lvl[IX_CH1]),
        .a_tog(s_tog[IX_CH0]),
        .b_tog(s_tog[IX_CH1]),
        .step (q_step),
        .down (q_down)
    );

    always_comb begin
        unique case (st_q.sel)
            TS_EXT: begin trg_lvl = s_lvl[IX_TRG]; trg_tog = s_tog[IX_TRG]; end
            TS_CH0: begin trg_lvl = s_lvl[IX_CH0]; trg_tog = s_tog[IX_CH0]; end
            TS_CH1: begin trg_lvl = s_lvl[IX_CH1]; trg_tog = s_tog[IX_CH1]; end
            default: begin trg_lvl = 1'b0; trg_tog = 1'b0; end
        endcase
        trg_rise = trg_lvl & trg_tog;
    end

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        is_quad  = (mode_e == SM_QA) || (mode_e == SM_QB) || (mode_e == SM_QAB);

        if (mode_e == SM_FREE) st_d.sel = tsrc_e'(trig_sel);

        if (mode_e != SM_START) st_d.run = 1'b0;
        else if (trg_rise)      st_d.run = 1'b1;

        en   = cnt_en | ((mode_e == SM_START) & (st_q.run | trg_rise));
        down = dir_cfg;
        unique case (mode_e)
            SM_GATE:   step = en & trg_lvl;
            SM_EXTCLK: step = en & trg_rise;
            SM_QA, SM_QB, SM_QAB: begin
                step = en & q_step;
                down = q_down;
            end
            default:   step = en;
        endcase

        if (!is_quad) st_d.dir = dir_cfg;

        if ((mode_e == SM_RESTART) && trg_rise) begin
            st_d.cnt = dir_cfg ? arr : '0;
            st_d.upd = 1'b1;
        end else if (step) begin
            st_d.dir = down;
            if (!down) begin
                if (st_q.cnt >= arr) begin
                    st_d.cnt = '0;
                    st_d.upd = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else begin
                if (st_q.cnt == '0) begin
                    st_d.cnt = arr;
                    st_d.upd = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, dir: 1'b0, upd: 1'b0, run: 1'b0, sel: TS_EXT};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign dir_o = st_q.dir;
    assign upd_o = st_q.upd;

    // R2: free mode with enable low keeps the count
    p_hold_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && !cnt_en) |=> $stable(cnt_o));

    // R12: without an update event the count moves by at most one
    p_single_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_o |-> ((cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + ONE)
                    || (cnt_o == $past(cnt_o) - ONE)));

    // R3: an update event leaves the count at 0 or at the reload value
    p_upd_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> ((cnt_o == '0) || (cnt_o == $past(arr))));

    // R8: gated mode with a low trigger keeps the count
    p_gate_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd5 && !trg_lvl) |=> $stable(cnt_o));

    // R11: trigger selection frozen outside free mode
    p_sel_frozen_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != 3'd0) |=> $stable(st_q.sel));
endmodule

// File: tb/slave_timer_tb_top.sv
module slave_timer_tb_top;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnt_en = 1'b0;
    logic [2:0]       mode = 3'd0;
    logic [1:0]       trig_sel = 2'd0;
    logic             dir_cfg = 1'b0;
    logic [CNT_W-1:0] arr = 16'd1000;
    logic             ch0_in = 1'b0;
    logic             ch1_in = 1'b0;
    logic             trig_in = 1'b0;
    logic [CNT_W-1:0] cnt_o;
    logic             dir_o;
    logic             upd_o;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    slave_timer #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .mode(mode),
        .trig_sel(trig_sel), .dir_cfg(dir_cfg), .arr(arr),
        .ch0_in(ch0_in), .ch1_in(ch1_in), .trig_in(trig_in),
        .cnt_o(cnt_o), .dir_o(dir_o), .upd_o(upd_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] m);
        @(negedge clk);
        rst_n = 1'b0; cnt_en = 1'b0; mode = m; trig_sel = 2'd0;
        dir_cfg = 1'b0; arr = 16'd1000; ch0_in = 1'b0; ch1_in = 1'b0; trig_in = 1'b0;
        cycles(2);
        rst_n = 1'b1;
        cycles(1);
    endtask

    task automatic quad_step(input logic a, input logic b);
        ch0_in = a; ch1_in = b;
        cycles(3);
    endtask

    task automatic t_reset;
        do_reset(3'd0);
        check("R1 cnt", cnt_o, 0);
        check("R1 dir", dir_o, 0);
        check("R1 upd", upd_o, 0);
    endtask

    task automatic t_free;
        do_reset(3'd0);
        cnt_en = 1'b1;
        cycles(5);
        cnt_en = 1'b0;
        check("R2 up count", cnt_o, 5);
        cycles(4);
        check("R2 hold", cnt_o, 5);
        dir_cfg = 1'b1; cnt_en = 1'b1;
        cycles(2);
        cnt_en = 1'b0;
        check("R2 down count", cnt_o, 3);
        check("R2 dir", dir_o, 1);
    endtask

    task automatic t_wrap;
        do_reset(3'd0);
        arr = 16'd3; cnt_en = 1'b1;
        cycles(3);
        check("R3 before wrap upd", upd_o, 0);
        cycles(1);
        cnt_en = 1'b0;
        check("R3 up wrap cnt", cnt_o, 0);
        check("R3 up wrap upd", upd_o, 1);
        cycles(1);
        check("R3 upd one cycle", upd_o, 0);
        dir_cfg = 1'b1; cnt_en = 1'b1;
        cycles(1);
        cnt_en = 1'b0;
        check("R3 down wrap cnt", cnt_o, 3);
        check("R3 down wrap upd", upd_o, 1);
    endtask

    task automatic t_quad;
        do_reset(3'd1);
        cnt_en = 1'b1;
        quad_step(1, 0); quad_step(1, 1); quad_step(0, 1); quad_step(0, 0);
        check("R4 ch0 edges fwd", cnt_o, 2);
        check("R4 dir up", dir_o, 0);
        quad_step(0, 1); quad_step(1, 1); quad_step(1, 0); quad_step(0, 0);
        check("R4 ch0 edges rev", cnt_o, 0);
        do_reset(3'd2);
        cnt_en = 1'b1;
        quad_step(1, 0); quad_step(1, 1); quad_step(0, 1); quad_step(0, 0);
        check("R5 ch1 edges fwd", cnt_o, 2);
        do_reset(3'd3);
        cnt_en = 1'b1;
        quad_step(1, 0); quad_step(1, 1); quad_step(0, 1); quad_step(0, 0);
        check("R6 both edges fwd", cnt_o, 4);
        for (int i = 0; i < 2; i++) begin
            quad_step(0, 1); quad_step(1, 1); quad_step(1, 0); quad_step(0, 0);
        end
        check("R6 both edges rev wrap", cnt_o, 997);
        check("R6 dir down", dir_o, 1);
    endtask

    task automatic t_restart;
        do_reset(3'd0);
        cnt_en = 1'b1;
        cycles(5);
        cnt_en = 1'b0; mode = 3'd4;
        cycles(3);
        check("R7 idle hold", cnt_o, 5);
        trig_in = 1'b1;
        cycles(1);
        check("R12 not yet", cnt_o, 5);
        cycles(1);
        check("R7 reload up", cnt_o, 0);
        check("R7 upd", upd_o, 1);
        cycles(1);
        check("R7 upd one cycle", upd_o, 0);
        trig_in = 1'b0; dir_cfg = 1'b1;
        cycles(3);
        trig_in = 1'b1;
        cycles(2);
        check("R7 reload down", cnt_o, 1000);
        trig_in = 1'b0;
    endtask

    task automatic t_gate;
        do_reset(3'd5);
        cnt_en = 1'b1;
        cycles(5);
        check("R8 low holds", cnt_o, 0);
        trig_in = 1'b1;
        cycles(4);
        trig_in = 1'b0;
        cycles(3);
        check("R8 gated count", cnt_o, 4);
    endtask

    task automatic t_start;
        do_reset(3'd6);
        cycles(3);
        check("R9 idle", cnt_o, 0);
        trig_in = 1'b1;
        cycles(4);
        check("R9 started", cnt_o, 3);
        trig_in = 1'b0;
        cycles(3);
        check("R9 keeps running", cnt_o, 6);
    endtask

    task automatic t_extclk;
        do_reset(3'd7);
        cnt_en = 1'b1;
        for (int i = 0; i < 3; i++) begin
            trig_in = 1'b1; cycles(2);
            trig_in = 1'b0; cycles(2);
        end
        cycles(2);
        check("R10 edges", cnt_o, 3);
        trig_in = 1'b1;
        cycles(8);
        check("R10 long high once", cnt_o, 4);
        trig_in = 1'b0;
    endtask

    task automatic t_sel;
        do_reset(3'd0);
        cycles(2);
        mode = 3'd7; cnt_en = 1'b1; trig_sel = 2'd1;
        cycles(2);
        ch0_in = 1'b1;
        cycles(3);
        ch0_in = 1'b0;
        cycles(3);
        check("R11 change ignored", cnt_o, 0);
        trig_in = 1'b1;
        cycles(3);
        trig_in = 1'b0;
        check("R11 held source", cnt_o, 1);
        mode = 3'd0; cnt_en = 1'b0;
        cycles(2);
        mode = 3'd7; cnt_en = 1'b1;
        ch0_in = 1'b1;
        cycles(3);
        ch0_in = 1'b0;
        check("R11 new source", cnt_o, 2);
    endtask

    initial begin
        t_reset();
        t_free();
        t_wrap();
        t_quad();
        t_restart();
        t_gate();
        t_start();
        t_extclk();
        t_sel();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule